// File: doc/BRIEF.md
# Port Change-Detect Interrupt Generator

This block watches a parallel input port and pulls an active-low interrupt line whenever the synchronized inputs differ from a reference snapshot. The snapshot is reloaded from the inputs each time the host reads the port. The snapshot is also reloaded on a bus stop strobe, which clears the interrupt. In the default snapshot mode the interrupt is a live comparison. If the inputs return to the reference value, the interrupt clears without any host action, and a brief excursion can go unseen.

An optional sticky change register keeps such an excursion visible. Every cycle it ORs in the bits that currently differ from the snapshot. A read returns the sticky bits alongside the port value and clears them. A mode input can switch the interrupt source so that the line stays asserted while any sticky bit is set. A synchronous reset takes a fresh snapshot of the inputs, so the line leaves reset deasserted.

Top module: `port_change_irq`

## Requirements
- R1: Each input bit passes through two clock flops. A level applied before clock edge k appears on `rd_data` after edge k+1, and only that synchronized value is compared.
- R2: In snapshot mode (`latch_mode`=0), `irq_n` is 0 exactly when the synchronized inputs differ from the snapshot.
- R3: In snapshot mode, `irq_n` returns to 1 when the synchronized inputs return to the snapshot value, with no read in between.
- R4: In a cycle with `rd_stb`=1, `rd_data` shows the synchronized inputs and `rd_chg` shows the sticky bits ORed with the current mismatch. At the next edge the snapshot takes the synchronized inputs and the sticky bits clear.
- R5: A `stop_stb` pulse alone reloads the snapshot and clears the sticky bits in the same way as a read, so `irq_n` reads 1 in the following cycle unless the inputs move again.
- R6: With the sticky register enabled, a bit of `rd_chg` that is set stays set until a read or stop. An input pulse that returns to the snapshot value before a read still shows in `rd_chg`.
- R7: In latched mode (`latch_mode`=1), `irq_n` is 0 while any sticky bit or any mismatch bit is set.
- R8: `rd_stb` and `stop_stb` high in the same cycle act as one read: the snapshot is reloaded once, the sticky bits clear, and the outputs match a lone read.
- R9: While `rst` is 1, each edge loads the snapshot from the synchronized inputs and clears the sticky bits. With steady inputs, `irq_n` is 1 and `rd_chg` is 0 after reset.
- R10: A difference that enters the synchronizer output on the edge that completes a read is caught against the new snapshot in the next cycle. It then latches into the sticky bits and is not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | WIDTH | Asynchronous port inputs |
| rd_stb | input | 1 | Host read of the port, one cycle |
| stop_stb | input | 1 | Bus stop event, one cycle |
| latch_mode | input | 1 | 0: live mismatch drives interrupt; 1: sticky bits drive interrupt |
| rd_data | output | WIDTH | Synchronized input value |
| rd_chg | output | WIDTH | Sticky change bits ORed with current mismatch |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The collision that matters is a read and an input change that meet in the same cycle. It occurs when a new value reaches the synchronizer output just as the read reloads the snapshot and clears the sticky bits. The bench drives input edges on the cycle before and the cycle of a read, and sometimes pulses read and stop together. It then checks that the moved bit shows against the new snapshot and latches into the sticky bits in the following cycle. Random traffic repeats the collision many times, and a reference model computed from the requirements judges every cycle.

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int WIDTH     = 8,
  parameter bit STICKY_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             rd_stb,
  input  logic             stop_stb,
  input  logic             latch_mode,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] rd_chg,
  output logic             irq_n
);

  logic [WIDTH-1:0] meta_q, sync_q, snap_q, stk_q, diff;
  logic             rearm;

  assign rearm = rd_stb | stop_stb;
  assign diff  = sync_q ^ snap_q;

  always_ff @(posedge clk) begin
    meta_q <= pin_in;
    sync_q <= meta_q;
  end

  always_ff @(posedge clk) begin
    if (rst || rearm) snap_q <= sync_q;
  end

  generate
    if (STICKY_EN) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst || rearm) stk_q <= '0;
        else              stk_q <= stk_q | diff;
      end
    end else begin : g_nosticky
      assign stk_q = '0;
    end
  endgenerate

  assign rd_data = sync_q;
  assign rd_chg  = stk_q | diff;
  assign irq_n   = latch_mode ? ~|(stk_q | diff) : ~|diff;

  assert_snap_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !rearm |=> $stable(snap_q));

  assert_rearm_loads_R4: assert property (@(posedge clk) disable iff (rst)
    rearm |=> (snap_q == $past(sync_q)) && (stk_q == '0));

  assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !rearm |=> (($past(stk_q) & ~stk_q) == '0));

  assert_latched_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && (stk_q != '0)) |-> !irq_n);

  assert_live_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (!latch_mode && (sync_q == snap_q)) |-> irq_n);

endmodule

// File: tb/tb_port_change_irq.sv
`timescale 1ns/1ps
module tb_port_change_irq;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin_in = '0;
  logic         rd_stb = 1'b0, stop_stb = 1'b0, latch_mode = 1'b0;
  logic [W-1:0] rd_data, rd_chg;
  logic         irq_n;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_s1 = '0, m_s2 = '0, m_snap = '0, m_stk = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_change_irq #(.WIDTH(W), .STICKY_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rd_stb(rd_stb), .stop_stb(stop_stb),
    .latch_mode(latch_mode), .rd_data(rd_data), .rd_chg(rd_chg), .irq_n(irq_n));

  function automatic logic exp_irq_n(logic lm, logic [W-1:0] s2, logic [W-1:0] sn, logic [W-1:0] st);
    return lm ? ~|(st | (s2 ^ sn)) : ~|(s2 ^ sn);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [W-1:0] p, logic rd, logic st, logic lm, string tag);
    logic clr;
    pin_in = p; rd_stb = rd; stop_stb = st; latch_mode = lm;
    #0.5;
    chk(tag, 32'(irq_n), 32'(exp_irq_n(lm, m_s2, m_snap, m_stk)), "irq_n");
    chk(tag, 32'(rd_data), 32'(m_s2), "rd_data");
    chk(tag, 32'(rd_chg), 32'(m_stk | (m_s2 ^ m_snap)), "rd_chg");
    @(posedge clk);
    clr = rst | rd | st;
    if (clr) begin m_snap = m_s2; m_stk = '0; end
    else m_stk = m_stk | (m_s2 ^ m_snap);
    m_s2 = m_s1; m_s1 = p;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      pin_in = 8'h00; @(posedge clk); m_s2 = m_s1; m_s1 = 8'h00; m_snap = m_s2; m_stk = '0; @(negedge clk);
    end
    step(8'h00, 0, 0, 0, "R9");
    m_snap = 8'h00; m_stk = '0; m_s2 = 8'h00; m_s1 = 8'h00;
    rst = 1'b0;
    step(8'h00, 0, 0, 0, "R9");
    chk("R9", 32'(irq_n), 32'd1, "irq_n after reset");
    // R1: two-flop latency
    step(8'h21, 0, 0, 0, "R1");
    chk("R1", 32'(rd_data), 32'h00, "rd_data one edge");
    step(8'h21, 0, 0, 0, "R1");
    chk("R1", 32'(rd_data), 32'h21, "rd_data two edges");
    chk("R2", 32'(irq_n), 32'd0, "irq_n on mismatch");
    // R3: self clear on return
    step(8'h00, 0, 0, 0, "R3");
    step(8'h00, 0, 0, 0, "R3");
    chk("R3", 32'(irq_n), 32'd1, "irq_n after return");
    chk("R6", 32'(rd_chg), 32'h21, "sticky keeps pulse");
    // R7: latched mode
    step(8'h00, 0, 0, 1, "R7");
    chk("R7", 32'(irq_n), 32'd0, "latched irq");
    // R4: read clears
    step(8'h00, 1, 0, 1, "R4");
    chk("R4", 32'(rd_chg), 32'h00, "sticky cleared");
    chk("R4", 32'(irq_n), 32'd1, "irq after read");
    // R5: stop alone
    step(8'h0f, 0, 0, 0, "R5");
    step(8'h0f, 0, 0, 0, "R5");
    step(8'h0f, 0, 1, 0, "R5");
    chk("R5", 32'(irq_n), 32'd1, "irq after stop");
    // R8: read and stop together
    step(8'h70, 0, 0, 0, "R8");
    step(8'h70, 0, 0, 0, "R8");
    step(8'h70, 1, 1, 0, "R8");
    chk("R8", 32'(rd_chg), 32'h00, "sticky after joint");
    chk("R8", 32'(irq_n), 32'd1, "irq after joint");
    // R10: change arriving on the read edge
    step(8'h71, 0, 0, 0, "R10");
    step(8'h71, 1, 0, 0, "R10");
    chk("R10", 32'(rd_chg), 32'h01, "re-latched bit");
    step(8'h70, 0, 0, 0, "R10");
    step(8'h70, 0, 0, 0, "R10");
    chk("R10", 32'(rd_chg), 32'h01, "re-latched held");
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] p;
      int r;
      r = $urandom_range(0, 9);
      p = (r < 3) ? W'($urandom) : (pin_in ^ (W'(1) << $urandom_range(0, W-1)) & {W{r < 6}});
      step(p, $urandom_range(0, 5) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0,
           (i % 2) ? "R6" : "R2");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule